// File: doc/BRIEF.md
# Query-Based Victim Selector for an Inclusive Cache Set

This block chooses which way of one set of an inclusive last-level cache is replaced on a miss. It keeps the recency order of the set and the valid bit of each way. When a miss arrives and a way is still empty, that way is taken at once and no query is sent. When every way is valid, the block sends a back-invalidate query for the least recently used way toward the core caches. The cores answer reject if the line is still held in any core cache, and accept if it is not.

A rejected line is moved to the most recently used position, and the next least recently used way is queried. The loop ends on the first accept or after `TRY_LIMIT` queries. If the last query is also rejected, that candidate is evicted anyway and marked forced, so the cores must drop it. The chosen way appears as a one-cycle victim pulse and becomes the most recently used way of the set, because it will hold the new line. Hits in the set also move their way to the most recently used position. Victim selection work therefore grows with the number of misses and not with the number of core hits.

The miss input, the query output and the response input are valid/ready channels. A transfer takes place on a clock edge where both valid and ready are high. Once the block raises the query valid, it keeps it high and keeps the way stable until ready is seen. The block accepts a miss only while idle, and it raises the response ready only while a query is outstanding. The hit input, the victim pulse and the busy flag are plain signals with no handshake.

Top module: `llc_victim_query`

## Requirements
- R1: After reset, the block is idle with `miss_ready`=1, `busy`=0, `qry_valid`=0 and `vic_valid`=0. All ways are invalid, and the recency order runs from way 0 (least recent) to way WAYS-1 (most recent).
- R2: On an accepted miss, if any way is invalid, the lowest-numbered invalid way is chosen without a query. `vic_valid` pulses in the next cycle with that way and `vic_forced`=0, and the way then counts as valid.
- R3: On an accepted miss with all ways valid, the block raises `busy` and `qry_valid` from the next cycle, querying the least recently used way. `miss_ready` stays low until the selection ends.
- R4: A response with `rsp_reject`=0 makes the queried way the victim. `vic_valid` pulses in the cycle after the response transfer, with `vic_forced`=0, and the block returns to idle.
- R5: A response with `rsp_reject`=1 before the try limit moves the queried way to the most recently used position. The next query names the new least recently used way.
- R6: At most `TRY_LIMIT` queries (default 2) are sent per miss. A reject on the last allowed query still evicts that way, with `vic_forced`=1.
- R7: The victim way becomes the most recently used way. A `hit_valid` pulse while idle, in a cycle with no miss transfer, moves `hit_way` to the most recently used position.
- R8: `hit_valid` has no effect while `busy` is high or in the cycle of a miss transfer.
- R9: While `qry_valid`=1 and `qry_ready`=0, `qry_valid` stays high and `qry_way` stays stable.
- R10: `rsp_ready` is high only while a query has been sent and its answer is pending. `qry_valid` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Block is idle and takes a miss |
| hit_valid | input | 1 | Hit in this set, promotes a way |
| hit_way | input | $clog2(WAYS) | Way that hit |
| qry_valid | output | 1 | Back-invalidate query present |
| qry_ready | input | 1 | Cores take the query |
| qry_way | output | $clog2(WAYS) | Way being queried |
| rsp_valid | input | 1 | Core answer present |
| rsp_ready | output | 1 | Block waits for an answer |
| rsp_reject | input | 1 | 1 = line held in a core cache |
| vic_valid | output | 1 | One-cycle victim pulse |
| vic_way | output | $clog2(WAYS) | Chosen way |
| vic_forced | output | 1 | Victim taken after final reject |
| busy | output | 1 | Query loop running |

## Verification
Selection is tried in several ways. Filling an empty set tells the free-way path apart from the query path. A first-try accept, a single reject then accept, and rejects up to the limit show whether promotion moves to the right next candidate and whether forcing happens only at the limit. Hits placed while idle, alongside a miss transfer, and during a pending query show whether recency is updated only when allowed. A long run with resident masks that change per miss, plus stalled query ready and delayed answers, checks the handshake holds and the evolving recency order against a list-based model.

// File: rtl/llc_victim_query_pkg.sv
package llc_victim_query_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_ASK  = 2'd1,
    SEL_WAIT = 2'd2
  } sel_state_e;
endpackage

// File: rtl/lru_rank_stack.sv
module lru_rank_stack #(
  parameter int WAYS = 4,
  localparam int IW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_way,
  output logic [IW-1:0] lru_way,
  output logic [IW-1:0] next_way
);
  // rank 0 = least recent, WAYS-1 = most recent
  logic [IW-1:0] rank_q [WAYS];
  logic [IW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[w] <= IW'(w);
      end else if (touch_en) begin
        if (touch_way == IW'(w)) begin
          rank_q[w] <= IW'(WAYS - 1);
        end else if (rank_q[w] > touched_rank) begin
          rank_q[w] <= rank_q[w] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    lru_way  = '0;
    next_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_q[w] == '0)      lru_way  = IW'(w);
      if (rank_q[w] == IW'(1))  next_way = IW'(w);
    end
  end
endmodule

// File: rtl/free_way_pick.sv
module free_way_pick #(
  parameter int WAYS = 4,
  localparam int IW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid_vec,
  output logic            any_free,
  output logic [IW-1:0]   free_way
);
  assign any_free = ~&valid_vec;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) free_way = IW'(w);
    end
  end
endmodule

// File: rtl/llc_victim_query.sv
module llc_victim_query
  import llc_victim_query_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int TRY_LIMIT = 2,
  localparam int IW = $clog2(WAYS),
  localparam int TW = $clog2(TRY_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic          hit_valid,
  input  logic [IW-1:0] hit_way,
  output logic          qry_valid,
  input  logic          qry_ready,
  output logic [IW-1:0] qry_way,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_reject,
  output logic          vic_valid,
  output logic [IW-1:0] vic_way,
  output logic          vic_forced,
  output logic          busy
);
  sel_state_e    st_q;
  logic [IW-1:0] cand_q;
  logic [TW-1:0] tries_q;
  logic [WAYS-1:0] valid_q;
  logic          vic_valid_q, vic_forced_q;
  logic [IW-1:0] vic_way_q;

  logic          miss_fire, rsp_fire, at_limit;
  logic          any_free;
  logic [IW-1:0] free_way, lru_way, next_way, after_reject;
  logic          touch_en;
  logic [IW-1:0] touch_way;

  free_way_pick #(.WAYS(WAYS)) u_free (
    .valid_vec (valid_q),
    .any_free  (any_free),
    .free_way  (free_way)
  );

  lru_rank_stack #(.WAYS(WAYS)) u_rank (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .lru_way   (lru_way),
    .next_way  (next_way)
  );

  assign miss_ready = (st_q == SEL_IDLE);
  assign busy       = (st_q != SEL_IDLE);
  assign qry_valid  = (st_q == SEL_ASK);
  assign qry_way    = cand_q;
  assign rsp_ready  = (st_q == SEL_WAIT);
  assign vic_valid  = vic_valid_q;
  assign vic_way    = vic_way_q;
  assign vic_forced = vic_forced_q;

  assign miss_fire = miss_valid && miss_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign at_limit  = (tries_q == TW'(TRY_LIMIT));

  // candidate moves to MRU, so the new LRU is the old second when it was LRU
  assign after_reject = (lru_way != cand_q) ? lru_way : next_way;

  always_comb begin
    touch_en  = 1'b0;
    touch_way = cand_q;
    if (miss_fire && any_free) begin
      touch_en  = 1'b1;
      touch_way = free_way;
    end else if (rsp_fire) begin
      touch_en  = 1'b1;
      touch_way = cand_q;
    end else if (miss_ready && hit_valid && !miss_fire) begin
      touch_en  = 1'b1;
      touch_way = hit_way;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= SEL_IDLE;
      cand_q       <= '0;
      tries_q      <= '0;
      valid_q      <= '0;
      vic_valid_q  <= 1'b0;
      vic_way_q    <= '0;
      vic_forced_q <= 1'b0;
    end else begin
      vic_valid_q <= 1'b0;
      unique case (st_q)
        SEL_IDLE: begin
          if (miss_fire) begin
            if (any_free) begin
              vic_valid_q        <= 1'b1;
              vic_way_q          <= free_way;
              vic_forced_q       <= 1'b0;
              valid_q[free_way]  <= 1'b1;
            end else begin
              cand_q  <= lru_way;
              tries_q <= TW'(1);
              st_q    <= SEL_ASK;
            end
          end
        end
        SEL_ASK: begin
          if (qry_ready) st_q <= SEL_WAIT;
        end
        SEL_WAIT: begin
          if (rsp_valid) begin
            if (!rsp_reject || at_limit) begin
              vic_valid_q  <= 1'b1;
              vic_way_q    <= cand_q;
              vic_forced_q <= rsp_reject;
              st_q         <= SEL_IDLE;
            end else begin
              cand_q  <= after_reject;
              tries_q <= tries_q + 1'b1;
              st_q    <= SEL_ASK;
            end
          end
        end
        default: st_q <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llc_victim_query_chk.sv
module llc_victim_query_chk #(
  parameter int WAYS      = 4,
  parameter int TRY_LIMIT = 2,
  localparam int IW = $clog2(WAYS),
  localparam int CW = $clog2(TRY_LIMIT + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic          miss_ready,
  input logic          qry_valid,
  input logic          qry_ready,
  input logic [IW-1:0] qry_way,
  input logic          rsp_ready,
  input logic          busy,
  input logic          vic_valid,
  input logic          vic_forced
);
  logic [CW-1:0] qcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt_q <= '0;
    end else if (miss_valid && miss_ready) begin
      qcnt_q <= '0;
    end else if (qry_valid && qry_ready && qcnt_q != {CW{1'b1}}) begin
      qcnt_q <= qcnt_q + 1'b1;
    end
  end

  AST_ASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid && !qry_ready |=> qry_valid && $stable(qry_way)); // R9
  AST_BUSY_BLOCKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_ready); // R3
  AST_ASK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |-> busy); // R3
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt_q <= CW'(TRY_LIMIT)); // R6
  AST_FORCE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && vic_forced |-> qcnt_q == CW'(TRY_LIMIT)); // R6
  AST_FREE_NO_ASK: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && $past(miss_valid && miss_ready) |-> qcnt_q == '0 && !vic_forced); // R2
  AST_RSP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !qry_valid); // R10
endmodule

bind llc_victim_query llc_victim_query_chk #(
  .WAYS(WAYS), .TRY_LIMIT(TRY_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_way(qry_way),
  .rsp_ready(rsp_ready), .busy(busy), .vic_valid(vic_valid),
  .vic_forced(vic_forced)
);

// File: tb/llc_victim_query_bench.sv
module llc_victim_query_bench;
  localparam int WAYS  = 4;
  localparam int LIMIT = 2;
  localparam int IW    = $clog2(WAYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0, hit_valid = 1'b0, qry_ready = 1'b0;
  logic rsp_valid = 1'b0, rsp_reject = 1'b0;
  logic [IW-1:0] hit_way = '0;
  logic miss_ready, qry_valid, rsp_ready, vic_valid, vic_forced, busy;
  logic [IW-1:0] qry_way, vic_way;

  always #10 clk = ~clk;

  llc_victim_query #(.WAYS(WAYS), .TRY_LIMIT(LIMIT)) u_llc_victim_query (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .hit_valid(hit_valid), .hit_way(hit_way), .qry_valid(qry_valid),
    .qry_ready(qry_ready), .qry_way(qry_way), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_reject(rsp_reject), .vic_valid(vic_valid),
    .vic_way(vic_way), .vic_forced(vic_forced), .busy(busy)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  // stimulus knobs
  logic [WAYS-1:0] core_res = '0;
  int rsp_lat = 0, stall_mod = 1;

  // reference model
  int m_state = 0, m_cand = 0, m_tries = 0;
  int order[$];
  bit m_valid[WAYS];
  bit e_vic = 0, e_forced = 0, e_free = 0;
  int e_way = 0;
  bit pend = 0;
  int pend_way = 0, pend_cnt = 0;

  task automatic chk(string tag, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s (phase %s): %s actual %0d expected %0d", tag, phase, what, act, exp);
    end
  endtask

  function automatic void to_mru(int w);
    for (int i = 0; i < order.size(); i++) begin
      if (order[i] == w) begin
        order.delete(i);
        break;
      end
    end
    order.push_back(w);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cand = 0; m_tries = 0; e_vic = 0; pend = 0;
      order.delete();
      for (int w = 0; w < WAYS; w++) begin
        order.push_back(w);
        m_valid[w] = 0;
      end
    end else begin
      e_vic = 0;
      case (m_state)
        0: begin
          if (miss_valid) begin
            int fw;
            fw = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[w]) fw = w;
            if (fw >= 0) begin
              e_vic = 1; e_way = fw; e_forced = 0; e_free = 1;
              m_valid[fw] = 1;
              to_mru(fw);
            end else begin
              m_cand = order[0]; m_tries = 1; m_state = 1;
            end
          end else if (hit_valid) begin
            to_mru(int'(hit_way));
          end
        end
        1: begin
          if (qry_ready) begin
            m_state = 2; pend = 1; pend_way = m_cand; pend_cnt = rsp_lat;
          end
        end
        default: begin
          if (rsp_valid) begin
            pend = 0;
            to_mru(m_cand);
            if (!rsp_reject || m_tries == LIMIT) begin
              e_vic = 1; e_way = m_cand; e_forced = rsp_reject; e_free = 0;
              m_state = 0;
            end else begin
              m_cand = order[0]; m_tries++; m_state = 1;
            end
          end
        end
      endcase
    end
  end

  // compare then drive responder, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3", int'(miss_ready), int'(m_state == 0), "miss_ready");
      chk("R3", int'(busy), int'(m_state != 0), "busy");
      chk("R3", int'(qry_valid), int'(m_state == 1), "qry_valid");
      if (m_state == 1) chk("R5", int'(qry_way), m_cand, "qry_way");
      chk("R10", int'(rsp_ready), int'(m_state == 2), "rsp_ready");
      chk("R4", int'(vic_valid), int'(e_vic), "vic_valid");
      if (e_vic) begin
        chk(e_free ? "R2" : "R7", int'(vic_way), e_way, "vic_way");
        chk("R6", int'(vic_forced), int'(e_forced), "vic_forced");
      end
    end
    qry_ready = (stall_mod <= 1) || (cyc % stall_mod == 0);
    if (pend) begin
      if (pend_cnt > 0) begin
        rsp_valid = 0;
        pend_cnt--;
      end else begin
        rsp_valid = 1;
        rsp_reject = core_res[pend_way];
      end
    end else begin
      rsp_valid = 0;
    end
  end

  task automatic do_miss(bit with_hit, int hw);
    bit r;
    @(negedge clk);
    miss_valid = 1;
    hit_valid = with_hit;
    hit_way = IW'(hw);
    forever begin
      r = miss_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    miss_valid = 0;
    hit_valid = 0;
  endtask

  task automatic do_hit(int w);
    @(negedge clk);
    hit_valid = 1; hit_way = IW'(w);
    @(negedge clk);
    hit_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_state != 0 || e_vic);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", int'(miss_ready), 1, "miss_ready after reset");
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R1", int'(qry_valid), 0, "qry_valid after reset");
    chk("R1", int'(vic_valid), 0, "vic_valid after reset");

    phase = "R2";                 // fills ways 0..3 with no query
    for (int i = 0; i < WAYS; i++) do_miss(0, 0);
    wait_idle();

    phase = "R4";                 // accept first query
    core_res = '0;
    do_miss(0, 0); wait_idle();

    phase = "R5";                 // one reject then accept
    core_res = 4'b0010;
    do_miss(0, 0); wait_idle();

    phase = "R6";                 // rejects up to the limit, forced eviction
    core_res = 4'b1111;
    do_miss(0, 0); wait_idle();

    phase = "R7";                 // idle hit reorders
    core_res = '0;
    do_hit(1);
    do_miss(0, 0); wait_idle();

    phase = "R8";                 // hits on miss cycle and while busy
    rsp_lat = 4;
    do_miss(1, 0);
    do_hit(0);
    wait_idle();
    do_miss(0, 0); wait_idle();

    phase = "R9";                 // stalled query ready
    stall_mod = 3; rsp_lat = 2; core_res = 4'b0101;
    for (int i = 0; i < 4; i++) begin
      do_miss(0, 0); wait_idle();
    end

    phase = "R3";                 // mixed long run
    for (int i = 0; i < 40; i++) begin
      core_res = WAYS'((i * 5 + 3) & 4'hF);
      rsp_lat = i % 3;
      stall_mod = 1 + (i % 3);
      if (i % 3 == 0) do_hit(i % WAYS);
      do_miss(i % 4 == 1, (i + 2) % WAYS);
      wait_idle();
    end
    finish_run();
  end
endmodule